// File: doc/BRIEF.md
# Eight-Decade Decimal Event Counter with Display Latch

This block totals single-cycle events in a chain of decimal digits. The lowest digit sees every event. Each higher digit advances only when the digit below it rolls from nine back to zero. Every digit stays in BCD, so the running total can be read without any binary-to-decimal conversion. A display strobe takes a snapshot of all digits into an output bank. The same strobe copies a sticky overflow state into an active-low flag. Between strobes the outputs do not move, so a readout path can scan a stable value while counting continues underneath.

The overflow tracker is a two-state machine. It starts in OVF_CLEAR. It takes the transition "wrap" to OVF_SET on the event that rolls the all-nines total back to zero. It then holds in OVF_SET through every later event, and only the transition "reset" returns it to OVF_CLEAR. The digit count is a parameter. It is eight by default, which gives a largest total of 99999999.

Top module: `bcd_event_counter`

## Requirements
- R1: Each cycle with `evt` high and `rst` low adds one to the total. The lowest digit advances, and a digit that goes from 9 to 0 advances the next digit up in the same cycle. With `evt` low the total does not change.
- R2: Each digit is a 4-bit BCD value from 0 to 9. Digit i sits at bits [4i+3:4i] of the count and of `shown_bcd`, and digit 0 is the least significant.
- R3: An event while every digit is 9 sets every digit to 0 and moves the overflow tracker from OVF_CLEAR to OVF_SET.
- R4: Once in OVF_SET, the overflow state stays set through any number of later events until reset.
- R5: A cycle with `show` high loads `shown_bcd` with the total held before that clock edge, and the new value is visible after the edge. An event in the same cycle is not part of that snapshot.
- R6: A strobe also loads `ovf_shown_n` with the inverted overflow state, so 0 means an overflow was seen. A wrap in the same cycle as a strobe shows up only at the next strobe.
- R7: In cycles with `show` low, `shown_bcd` and `ovf_shown_n` hold their values, whatever `evt` does.
- R8: A synchronous, active-high `rst` clears every digit, the overflow state and `shown_bcd`, and sets `ovf_shown_n` to 1. It takes priority over `evt` and `show` in the same cycle.
- R9: The parameter `NUM_DIGITS` sets the number of digits, and `shown_bcd` is 4*`NUM_DIGITS` bits wide. With three digits the wrap comes on the 1000th event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | 1 | Single-cycle count event |
| show | input | 1 | Display strobe; loads the snapshot bank |
| shown_bcd | output | 4*NUM_DIGITS | Latched BCD digits, digit 0 in the low nibble |
| ovf_shown_n | output | 1 | Latched overflow flag, active low |

## Verification
The bound checker checks on every cycle the properties that hold from cycle to cycle: each digit stays in range, the total is frozen without an event, the wrap clears the digits and sets the sticky state, strobes load and non-strobe cycles hold, and reset clears everything. What it cannot show is that the decimal arithmetic lands on the right total after long runs of events. The bench shows that with scenarios checked against a reference model. The scenarios cover carries through several digits, a strobe in the same cycle as an event, the strobe-versus-wrap ordering on a three-digit copy, and reset winning over a pending event and strobe.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DIGIT_TOP = 4'd9;

    typedef enum logic {
        OVF_CLEAR = 1'b0,
        OVF_SET   = 1'b1
    } ovf_state_e;
endpackage

// File: rtl/bcd_decade.sv
module bcd_decade
    import bcd_cnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               inc,
    output logic [DIGIT_W-1:0] digit,
    output logic               carry
);
    logic [DIGIT_W-1:0] digit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            digit_q <= '0;
        end else if (inc) begin
            if (digit_q == DIGIT_TOP) begin
                digit_q <= '0;
            end else begin
                digit_q <= digit_q + 1'b1;
            end
        end
    end

    // Ripple to the next digit when this one rolls over
    assign carry = inc && (digit_q == DIGIT_TOP);
    assign digit = digit_q;
endmodule

// File: rtl/ovf_tracker.sv
module ovf_tracker
    import bcd_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    output logic flag
);
    ovf_state_e state_q;
    ovf_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_CLEAR: if (wrap) state_d = OVF_SET;
            OVF_SET:   state_d = OVF_SET;
            default:   state_d = OVF_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OVF_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flag = (state_q == OVF_SET);
    end
endmodule

// File: rtl/bcd_snapshot.sv
module bcd_snapshot #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    input  logic             ovf_in,
    output logic [WIDTH-1:0] q,
    output logic             ovf_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            ovf_n <= 1'b1;
        end else if (load) begin
            q     <= d;
            ovf_n <= ~ovf_in;
        end
    end
endmodule

// File: rtl/bcd_event_counter.sv
module bcd_event_counter
    import bcd_cnt_pkg::*;
#(
    parameter int NUM_DIGITS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          evt,
    input  logic                          show,
    output logic [NUM_DIGITS*DIGIT_W-1:0] shown_bcd,
    output logic                          ovf_shown_n
);
    localparam int BCD_W = NUM_DIGITS * DIGIT_W;

    logic [NUM_DIGITS:0] chain;
    logic [BCD_W-1:0]    cnt_bcd;
    logic                full_evt;
    logic                ovf_flag;

    assign chain[0] = evt;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
        bcd_decade u_dec (
            .clk   (clk),
            .rst   (rst),
            .inc   (chain[g]),
            .digit (cnt_bcd[g*DIGIT_W +: DIGIT_W]),
            .carry (chain[g+1])
        );
    end

    assign full_evt = chain[NUM_DIGITS];

    ovf_tracker u_ovf (
        .clk  (clk),
        .rst  (rst),
        .wrap (full_evt),
        .flag (ovf_flag)
    );

    bcd_snapshot #(.WIDTH(BCD_W)) u_snap (
        .clk    (clk),
        .rst    (rst),
        .load   (show),
        .d      (cnt_bcd),
        .ovf_in (ovf_flag),
        .q      (shown_bcd),
        .ovf_n  (ovf_shown_n)
    );
endmodule

// File: rtl/bcd_event_counter_chk.sv
module bcd_event_counter_chk #(
    parameter int NUM_DIGITS = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    evt,
    input logic                    show,
    input logic [NUM_DIGITS*4-1:0] cnt_bcd,
    input logic                    full_evt,
    input logic                    ovf_flag,
    input logic [NUM_DIGITS*4-1:0] shown_bcd,
    input logic                    ovf_shown_n
);
    function automatic logic digits_ok(input logic [NUM_DIGITS*4-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    logic rst_prev;
    always_ff @(posedge clk) rst_prev <= rst;

    // R8: one cycle after reset every state element is cleared
    always @(negedge clk) begin
        if (rst_prev === 1'b1) begin
            a_reset_clears_r8: assert (cnt_bcd == '0 && !ovf_flag &&
                                       shown_bcd == '0 && ovf_shown_n)
                else $error("reset did not clear state");
        end
    end

    p_idle_holds_r1: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(cnt_bcd));

    p_digit_range_r2: assert property (@(posedge clk) disable iff (rst)
        digits_ok(cnt_bcd) && digits_ok(shown_bcd));

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
        full_evt |=> (cnt_bcd == '0 && ovf_flag));

    p_sticky_ovf_r4: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    p_strobe_loads_r5: assert property (@(posedge clk) disable iff (rst)
        show |=> shown_bcd == $past(cnt_bcd));

    p_strobe_ovf_r6: assert property (@(posedge clk) disable iff (rst)
        show |=> ovf_shown_n == !$past(ovf_flag));

    p_no_strobe_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !show |=> ($stable(shown_bcd) && $stable(ovf_shown_n)));
endmodule

bind bcd_event_counter bcd_event_counter_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt         (evt),
    .show        (show),
    .cnt_bcd     (cnt_bcd),
    .full_evt    (full_evt),
    .ovf_flag    (ovf_flag),
    .shown_bcd   (shown_bcd),
    .ovf_shown_n (ovf_shown_n)
);

// File: tb/bcd_event_counter_tb.sv
`timescale 1ns/1ps
module bcd_event_counter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt = 1'b0;
    logic        show = 1'b0;
    logic [31:0] b8;
    logic        o8;
    logic [11:0] b3;
    logic        o3;

    always #2 clk = ~clk;

    bcd_event_counter u_dut (
        .clk(clk), .rst(rst), .evt(evt), .show(show),
        .shown_bcd(b8), .ovf_shown_n(o8)
    );

    // R9: three-digit copy shares the stimulus to reach the wrap quickly
    bcd_event_counter #(.NUM_DIGITS(3)) u_dut_w3 (
        .clk(clk), .rst(rst), .evt(evt), .show(show),
        .shown_bcd(b3), .ovf_shown_n(o3)
    );

    typedef struct {
        logic [31:0] e8;
        logic        eo8;
        logic [11:0] e3;
        logic        eo3;
        string       tag;
    } exp_t;

    exp_t   sb_q[$];
    exp_t   last;
    int     checks = 0;
    int     fails = 0;
    longint tot = 0;

    function automatic logic [31:0] to_bcd(input longint v);
        logic [31:0] r;
        longint x;
        r = '0;
        x = v;
        for (int i = 0; i < 8; i++) begin
            r[i*4 +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    function automatic exp_t model_now(input string tag);
        exp_t e;
        logic [31:0] t3;
        e.e8  = to_bcd(tot % 100000000);
        e.eo8 = !(tot >= 100000000);
        t3    = to_bcd(tot % 1000);
        e.e3  = t3[11:0];
        e.eo3 = !(tot >= 1000);
        e.tag = tag;
        return e;
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmp_all(input exp_t e);
        cmp({e.tag, " bcd8"}, b8, e.e8);
        cmp({e.tag, " ovf8_n"}, {31'd0, o8}, {31'd0, e.eo8});
        cmp({e.tag, " bcd3"}, {20'd0, b3}, {20'd0, e.e3});
        cmp({e.tag, " ovf3_n"}, {31'd0, o3}, {31'd0, e.eo3});
    endtask

    // Driver: one cycle of stimulus; a strobe pushes the expected snapshot
    task automatic step(input bit e, input bit s, input string tag);
        @(negedge clk);
        evt  = e;
        show = s;
        if (s) begin
            last = model_now(tag);
            sb_q.push_back(last);
        end
        if (e) tot++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, "");
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; evt = 1'b1; show = 1'b1;
        tot = 0;
        @(negedge clk);
        rst = 1'b0; evt = 1'b0; show = 1'b0;
        last = model_now(tag);
        cmp_all(last);
    endtask

    // Monitor: pops one expected item per accepted strobe
    initial begin
        forever begin
            @(posedge clk);
            if (show === 1'b1 && rst === 1'b0) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL scoreboard empty actual=%h expected=item", b8);
                end else begin
                    cmp_all(sb_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        do_reset("R8 reset state");

        run(7);
        step(1'b0, 1'b1, "R1 R5 seven events");
        step(1'b1, 1'b1, "R5 event with strobe excluded");
        run(115);
        step(1'b0, 1'b1, "R1 R2 carry to hundreds");

        run(9);
        step(1'b0, 1'b0, "");
        cmp("R7 hold bcd8", b8, last.e8);
        cmp("R7 hold bcd3", {20'd0, b3}, {20'd0, last.e3});

        // Reach 999 on the three-digit copy
        run(999 - int'(tot));
        step(1'b0, 1'b1, "R9 three digits at max");
        step(1'b1, 1'b1, "R6 wrap with strobe not yet shown");
        step(1'b0, 1'b1, "R3 R6 wrap shown as zero and overflow");
        run(5);
        step(1'b0, 1'b1, "R4 overflow sticky");

        do_reset("R8 reset over event and strobe");
        run(1234);
        step(1'b0, 1'b1, "R2 digit positions 1234");
        step(1'b0, 1'b0, "");

        repeat (3) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule